// File: doc/BRIEF.md
# FIFO Counter Self-Test Engine with Triple Signature Compression

This block is a self-test controller for one embedded RAM/FIFO slice. Once started, it drives the slice's write and read address counters and its occupancy (full/empty) logic through the whole address range of each supported depth. Every observed response is folded into one of three 16-bit CRC signatures: one for the data returned on the read side, one for the write address sequence, and one for the status flags. A behavioural RAM stands in for the storage array. Test clock, data in, data out and the shift/update/capture strobes come from an external test access controller.

Software or a tester shifts an 8-bit control word into a serial register and pulses update. That word picks one of four counter-exercise patterns and either one depth or all depths, and can request a start. Several copies of the block can share the same update strobe, so one command starts them together. After the run the tester pulses capture and shifts out a done bit followed by the three signatures. It then compares them against values computed offline.

The sequencer has four states. `ST_IDLE` waits for an accepted start request and goes to `ST_LOAD`. `ST_LOAD` seeds the signatures, picks the first depth and goes to `ST_RUN`. `ST_RUN` issues one pattern step per clock and goes to `ST_NEXT` after its last step. `ST_NEXT` clears the counters and then either returns to `ST_RUN` at the next larger depth or, after the last depth, sets done and returns to `ST_IDLE`.

Top module: `fifo_bist_engine`

## Requirements
- R1: After reset, the done bit reads 0 and all three signatures read 16'hFFFF.
- R2: Control word bits: [1:0] pattern, [4:2] depth code, [5] start, [7:6] reserved. The word is shifted in least significant bit first and takes effect on update. A word with start = 0 loads without running, so done stays 0 and the signatures stay unchanged.
- R3: Each depth D runs a fixed step count. Pattern 0 does D writes then D reads (2D steps). Pattern 1 alternates write and read, starting with a write (2D steps). Pattern 2 does D writes, then D steps that write and read together while full, then D reads (3D steps). Pattern 3 is pattern 0 with inverted write data. Pointers wrap modulo D.
- R4: Depth codes 0 to 5 select 128 << code words. Codes 6 and 7 run all six depths in ascending order within one test.
- R5: On every write step, the write signature absorbs the write address, zero-extended to 16 bits.
- R6: On every read step, the read signature absorbs the word read at the read address. The stored word is the write address for patterns 0 to 2 and its 12-bit complement for pattern 3.
- R7: On every run step, the flag signature absorbs {14'b0, full, empty}, sampled before that step's operation. Full means count == D and empty means count == 0.
- R8: Signatures use polynomial x^16+x^12+x^5+1 (16'h1021). Each 16-bit word is processed most significant bit first. All three are seeded to 16'hFFFF when a test starts.
- R9: Done is cleared at the update edge that starts a test. It is set exactly 1 + sum over depths of (steps + 1) clocks after that edge.
- R10: An update while a test is running is ignored, including its start bit. The test completes with the signatures and timing it would have had without the update.
- R11: Capture loads {flag, write, read signatures, done}. Done is the first bit out, followed by the read, write and flag signatures, each least significant bit first.
- R12: The reserved control bits have no effect on the test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tst_clk | input | 1 | Test clock for the scan path and the engine |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial data into the scan register |
| shift_en | input | 1 | Shift the scan register one place toward scan_out |
| capture_en | input | 1 | Load done and the signatures into the scan register |
| update_en | input | 1 | Transfer the top 8 scan bits into the control word |
| scan_out | output | 1 | Serial data out, bit 0 of the scan register |

## Verification
The bench sweeps every pattern over every single depth, and runs the all-depths codes. It checks the exact clock on which done first appears, so a missing or extra step, or a skipped depth, shows up as a latency miscompare. A flag decoded one count early or late alters the flag signature. A wrong wrap mask alters the write signature, and wrong write data or a misdirected read alters the read signature. An update during a run that changed the word or restarted the test would produce a different signature and a different latency. A reserved bit leaking into the decode would break the run that sets it.

// File: rtl/fbist_pkg.sv
package fbist_pkg;

    localparam int CRC_W  = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam int CTRL_W = 8;
    localparam int N_SIG  = 3;

    typedef enum logic [1:0] {
        MODE_FILL_DRAIN     = 2'd0,
        MODE_ALTERNATE      = 2'd1,
        MODE_WRAP           = 2'd2,
        MODE_FILL_DRAIN_INV = 2'd3
    } bist_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_NEXT
    } seq_state_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       start;
        logic [2:0] depth;
        logic [1:0] mode;
    } bist_ctrl_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                  input logic [CRC_W-1:0] word);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = cur;
        for (int i = CRC_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ word[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/fbist_crc.sv
module fbist_crc
    import fbist_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed,
    input  logic             en,
    input  logic [CRC_W-1:0] din,
    output logic [CRC_W-1:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc <= '1;
        else if (seed) crc <= '1;
        else if (en)   crc <= crc_step(crc, din);
    end

    assert_seed_all_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> (crc == '1));

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed && !en) |=> $stable(crc));

endmodule

// File: rtl/fbist_ram.sv
module fbist_ram #(
    parameter int AW = 12,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fbist_scan.sv
module fbist_scan
    import fbist_pkg::*;
#(
    parameter int SIG_BITS = N_SIG * CRC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_in,
    input  logic                shift_en,
    input  logic                capture_en,
    input  logic                update_en,
    input  logic                busy,
    input  logic                done,
    input  logic [SIG_BITS-1:0] sigs,
    output logic                scan_out,
    output bist_ctrl_t          ctrl,
    output logic                start_req
);

    localparam int SR_W = 1 + SIG_BITS;

    logic [SR_W-1:0] sr;
    bist_ctrl_t      staged;

    assign staged    = bist_ctrl_t'(sr[SR_W-1 -: CTRL_W]);
    assign start_req = update_en & ~busy & staged.start;
    assign scan_out  = sr[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            ctrl <= '0;
        end else begin
            if (capture_en)    sr <= {sigs, done};
            else if (shift_en) sr <= {scan_in, sr[SR_W-1:1]};
            if (update_en && !busy) ctrl <= staged;
        end
    end

    assert_ctrl_frozen_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && update_en) |=> $stable(ctrl));

    assert_no_start_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start_req);

endmodule

// File: rtl/fbist_seq.sv
module fbist_seq
    import fbist_pkg::*;
#(
    parameter int MIN_AW     = 7,
    parameter int NUM_DEPTHS = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [1:0]                       mode_i,
    input  logic [2:0]                       depth_i,
    output logic                             busy,
    output logic                             done,
    output logic                             seed,
    output logic                             run,
    output logic                             wr_en,
    output logic                             rd_en,
    output logic [MIN_AW+NUM_DEPTHS-2:0]     waddr,
    output logic [MIN_AW+NUM_DEPTHS-2:0]     raddr,
    output logic [MIN_AW+NUM_DEPTHS-2:0]     wdata,
    output logic                             full,
    output logic                             empty
);

    localparam int MAX_AW = MIN_AW + NUM_DEPTHS - 1;
    localparam int STEP_W = MAX_AW + 2;
    localparam logic [2:0] LAST_CODE = 3'(NUM_DEPTHS - 1);

    seq_state_e state, state_n;
    bist_mode_e mode;

    logic [2:0]        cur_code, last_code;
    logic [STEP_W-1:0] step, d_ext, step_last;
    logic [MAX_AW:0]   depth_w, depth_m1, cnt;
    logic [MAX_AW-1:0] mask, wptr, rptr;
    logic              all_sel, op_wr, op_rd;

    assign mode     = bist_mode_e'(mode_i);
    assign all_sel  = (depth_i >= 3'(NUM_DEPTHS));
    assign depth_w  = {{MAX_AW{1'b0}}, 1'b1} << (MIN_AW + 32'(cur_code));
    assign depth_m1 = depth_w - 1'b1;
    assign mask     = depth_m1[MAX_AW-1:0];
    assign d_ext    = STEP_W'(depth_w);

    always_comb begin
        unique case (mode)
            MODE_WRAP: step_last = d_ext + d_ext + d_ext - 1'b1;
            default:   step_last = d_ext + d_ext - 1'b1;
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_FILL_DRAIN, MODE_FILL_DRAIN_INV: begin
                op_wr = (step < d_ext);
                op_rd = !op_wr;
            end
            MODE_ALTERNATE: begin
                op_wr = !step[0];
                op_rd = step[0];
            end
            MODE_WRAP: begin
                op_wr = (step < d_ext + d_ext);
                op_rd = (step >= d_ext);
            end
        endcase
    end

    assign full  = (cnt == depth_w);
    assign empty = (cnt == '0);
    assign waddr = wptr;
    assign raddr = rptr;
    assign wdata = (mode == MODE_FILL_DRAIN_INV) ? ~wptr : wptr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state decode
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (start) state_n = ST_LOAD;
            ST_LOAD: state_n = ST_RUN;
            ST_RUN:  if (step == step_last) state_n = ST_NEXT;
            ST_NEXT: state_n = (cur_code == last_code) ? ST_IDLE : ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        busy  = (state != ST_IDLE);
        seed  = (state == ST_LOAD);
        run   = (state == ST_RUN);
        wr_en = run & op_wr;
        rd_en = run & op_rd;
    end

    // counters under test
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            cur_code  <= '0;
            last_code <= '0;
            step      <= '0;
            wptr      <= '0;
            rptr      <= '0;
            cnt       <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) done <= 1'b0;
                ST_LOAD: begin
                    cur_code  <= all_sel ? 3'd0 : depth_i;
                    last_code <= all_sel ? LAST_CODE : depth_i;
                    step      <= '0;
                    wptr      <= '0;
                    rptr      <= '0;
                    cnt       <= '0;
                end
                ST_RUN: begin
                    step <= step + 1'b1;
                    if (wr_en) wptr <= (wptr + 1'b1) & mask;
                    if (rd_en) rptr <= (rptr + 1'b1) & mask;
                    if (wr_en && !rd_en)      cnt <= cnt + 1'b1;
                    else if (rd_en && !wr_en) cnt <= cnt - 1'b1;
                end
                ST_NEXT: begin
                    step <= '0;
                    wptr <= '0;
                    rptr <= '0;
                    cnt  <= '0;
                    if (cur_code != last_code) cur_code <= cur_code + 1'b1;
                    else                       done     <= 1'b1;
                end
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= depth_w);

    assert_no_write_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |-> rd_en);

    assert_no_read_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_done_after_last_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state == ST_NEXT));

endmodule

// File: rtl/fifo_bist_engine.sv
module fifo_bist_engine
    import fbist_pkg::*;
#(
    parameter int MIN_AW     = 7,
    parameter int NUM_DEPTHS = 6
) (
    input  logic tst_clk,
    input  logic rst_n,
    input  logic scan_in,
    input  logic shift_en,
    input  logic capture_en,
    input  logic update_en,
    output logic scan_out
);

    localparam int MAX_AW   = MIN_AW + NUM_DEPTHS - 1;
    localparam int SIG_BITS = N_SIG * CRC_W;

    bist_ctrl_t          ctrl;
    logic                start_req, busy, done, seed, run;
    logic                wr_en, rd_en, full, empty;
    logic [MAX_AW-1:0]   waddr, raddr, wdata, rdata;
    logic [SIG_BITS-1:0] sig_bus;
    logic [N_SIG-1:0]    crc_en;
    logic [CRC_W-1:0]    crc_din [N_SIG];

    fbist_scan u_scan (
        .clk        (tst_clk),
        .rst_n      (rst_n),
        .scan_in    (scan_in),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .busy       (busy),
        .done       (done),
        .sigs       (sig_bus),
        .scan_out   (scan_out),
        .ctrl       (ctrl),
        .start_req  (start_req)
    );

    fbist_seq #(.MIN_AW(MIN_AW), .NUM_DEPTHS(NUM_DEPTHS)) u_seq (
        .clk     (tst_clk),
        .rst_n   (rst_n),
        .start   (start_req),
        .mode_i  (ctrl.mode),
        .depth_i (ctrl.depth),
        .busy    (busy),
        .done    (done),
        .seed    (seed),
        .run     (run),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .waddr   (waddr),
        .raddr   (raddr),
        .wdata   (wdata),
        .full    (full),
        .empty   (empty)
    );

    fbist_ram #(.AW(MAX_AW), .DW(MAX_AW)) u_ram (
        .clk   (tst_clk),
        .we    (wr_en),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    // signature lanes: 0 = read data, 1 = write address, 2 = status flags
    assign crc_en     = {run, wr_en, rd_en};
    assign crc_din[0] = CRC_W'(rdata);
    assign crc_din[1] = CRC_W'(waddr);
    assign crc_din[2] = CRC_W'({full, empty});

    for (genvar g = 0; g < N_SIG; g++) begin : g_sig
        fbist_crc u_crc (
            .clk   (tst_clk),
            .rst_n (rst_n),
            .seed  (seed),
            .en    (crc_en[g]),
            .din   (crc_din[g]),
            .crc   (sig_bus[g*CRC_W +: CRC_W])
        );
    end

endmodule

// File: tb/tb_fifo_bist_engine.sv
module tb_fifo_bist_engine;

    logic tst_clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_in = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
    logic scan_out;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 tst_clk = ~tst_clk;
    always @(posedge tst_clk) cyc <= cyc + 1;

    fifo_bist_engine dut (
        .tst_clk    (tst_clk),
        .rst_n      (rst_n),
        .scan_in    (scan_in),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .scan_out   (scan_out)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r = c;
        for (int b = 15; b >= 0; b--) begin
            if (r[15] ^ w[b]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic model(input int mode, input int code,
                         output logic [15:0] erd, output logic [15:0] ewr,
                         output logic [15:0] efl, output int elat);
        int lo, hi, e;
        erd = 16'hFFFF; ewr = 16'hFFFF; efl = 16'hFFFF;
        lo = (code >= 6) ? 0 : code;
        hi = (code >= 6) ? 5 : code;
        e = 1;
        for (int c = lo; c <= hi; c++) begin
            int d = 128 << c;
            int n = (mode == 2) ? 3 * d : 2 * d;
            int w = 0, r = 0, cnt = 0;
            for (int s = 0; s < n; s++) begin
                bit wr, rd;
                case (mode)
                    1:       begin wr = (s % 2 == 0); rd = !wr; end
                    2:       begin wr = (s < 2 * d); rd = (s >= d); end
                    default: begin wr = (s < d); rd = !wr; end
                endcase
                efl = ref_crc(efl, {14'd0, cnt == d, cnt == 0});
                if (wr) ewr = ref_crc(ewr, 16'(w));
                if (rd) erd = ref_crc(erd, (mode == 3) ? 16'((~r) & 12'hFFF) : 16'(r));
                if (wr) w = (w + 1) % d;
                if (rd) r = (r + 1) % d;
                cnt = cnt + (wr ? 1 : 0) - (rd ? 1 : 0);
            end
            e += n + 1;
        end
        elat = e + 1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_ctrl(input logic [7:0] w, output int t0);
        for (int i = 0; i < 8; i++) begin
            @(negedge tst_clk);
            shift_en = 1'b1; scan_in = w[i];
        end
        @(negedge tst_clk);
        shift_en = 1'b0; scan_in = 1'b0; update_en = 1'b1;
        @(posedge tst_clk);
        #1 t0 = cyc;
        @(negedge tst_clk);
        update_en = 1'b0;
    endtask

    task automatic read_scan(output logic [48:0] v);
        @(negedge tst_clk);
        capture_en = 1'b1;
        @(posedge tst_clk);
        #1 v[0] = scan_out;
        for (int i = 1; i < 49; i++) begin
            @(negedge tst_clk);
            capture_en = 1'b0; shift_en = 1'b1; scan_in = 1'b0;
            @(posedge tst_clk);
            #1 v[i] = scan_out;
        end
        @(negedge tst_clk);
        shift_en = 1'b0; capture_en = 1'b0;
    endtask

    task automatic poll_done(input int t0, output int lat);
        lat = -1;
        for (int k = 0; k < 40000; k++) begin
            @(negedge tst_clk);
            capture_en = 1'b1;
            @(posedge tst_clk);
            #1;
            if (scan_out) begin
                lat = cyc - t0;
                break;
            end
        end
        @(negedge tst_clk);
        capture_en = 1'b0;
    endtask

    task automatic run_test(input int mode, input int code, input logic [1:0] rsvd,
                            input bit interfere, input string req);
        logic [15:0] erd, ewr, efl;
        logic [48:0] v;
        int elat, t0, lat, tdummy;
        model(mode, code, erd, ewr, efl, elat);
        load_ctrl({rsvd, 1'b1, 3'(code), 2'(mode)}, t0);
        if (interfere) begin
            repeat (40) @(negedge tst_clk);
            // R10: a different start word while running must be ignored
            load_ctrl({2'b00, 1'b1, 3'd0, 2'(mode ^ 2)}, tdummy);
        end
        poll_done(t0, lat);
        check(req, $sformatf("R9 done latency m%0d c%0d", mode, code), lat, elat);
        read_scan(v);
        check(req, "R11 done bit first", v[0], 1);
        check(req, $sformatf("R6 read sig m%0d c%0d", mode, code), v[16:1], erd);
        check(req, $sformatf("R5 write sig m%0d c%0d", mode, code), v[32:17], ewr);
        check(req, $sformatf("R7 flag sig m%0d c%0d", mode, code), v[48:33], efl);
    endtask

    initial begin
        logic [48:0] v;
        int t0;
        repeat (3) @(negedge tst_clk);
        rst_n = 1'b1;

        // R1: reset state through the scan path
        read_scan(v);
        check("R1", "done after reset", v[0], 0);
        check("R1", "read sig reset", v[16:1], 16'hFFFF);
        check("R1", "write sig reset", v[32:17], 16'hFFFF);
        check("R1", "flag sig reset", v[48:33], 16'hFFFF);

        // R2: load without start
        load_ctrl(8'b00_0_000_10, t0);
        repeat (60) @(negedge tst_clk);
        read_scan(v);
        check("R2", "no run without start: done", v[0], 0);
        check("R2", "no run without start: sig", v[48:1], {3{16'hFFFF}});

        // R3 R5 R6 R7 R8 R9 R11: every pattern at every single depth
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 6; c++)
                run_test(m, c, 2'b00, 1'b0, "R3");

        // R4: all-depths codes
        run_test(2, 7, 2'b00, 1'b0, "R4");
        run_test(1, 6, 2'b00, 1'b0, "R4");

        // R10: update during a run
        run_test(0, 2, 2'b00, 1'b1, "R10");

        // R12: reserved bits set
        run_test(3, 1, 2'b11, 1'b0, "R12");

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge tst_clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule